// File: doc/BRIEF.md
# CAN Controller Deferred Soft Reset and Autobaud Front End

This block sits in front of a CAN protocol engine and handles two control tasks. The first is a guarded soft reset. Software asks for it through a protected register write. The block holds the request until the engine has finished its current reception, transmission, lost arbitration or error handling. It then pulses the engine's register reset and error-counter clear strobes and sets a software-interrupt flag. The engine stays held until software withdraws the request. On release, the block raises either a resume pulse or a bus-off recovery pulse, chosen by the interrupt flag and the bus-off input.

The second task is autobaud listening. With autobaud set, the engine's receive input is the RX pin ANDed with the engine's own transmit bit, looped back inside the block. The TX pin is held recessive so that bits sent while the node is not yet synchronised never reach the bus. A correctly received frame then marks receive success even when no message buffer stores it.

Top module: `canfe_rst_abaud`

## Requirements
- R1: Read bit 0 is the reset request. Only a write with `wr_prot_i` high in the same cycle as `wr_en_i` changes it, and it takes the value of write bit 0. A write with `wr_prot_i` low leaves the request unchanged.
- R2: When the request is set and has not yet executed, it executes in any cycle where `rx_busy_i`, `tx_busy_i`, `arb_lost_i` and `err_act_i` are all low. While any of them is high, it waits.
- R3: In the cycle the reset executes, `reg_rst_o` and `cnt_clr_o` are high for exactly that cycle.
- R4: Read bit 3 is 0 before the reset has executed and goes to 1 at the clock edge that ends the executing cycle. It stays 1 until the request bit is cleared.
- R5: Read bit 2 is the software-interrupt flag. Reset execution sets it. An ordinary write loads it from write bit 2.
- R6: `eng_hold_o` equals read bit 3. In the single cycle after software clears the request of an executed reset, `run_o` pulses if the flag is 1 and `bus_off_i` is low, and `recover_o` pulses if `bus_off_i` is high.
- R7: At each clock edge where `bus_off_i` is high, the flag is forced to 0, which also blocks software writes to it. In the first cycle `bus_off_i` is low after being high, `cnt_clr_o` pulses, and the flag is set at the end of that cycle.
- R8: Read bit 1 is the autobaud mode, loaded from write bit 1 by any write. With autobaud set, `eng_rx_o` = `rx_pin_i` AND `eng_tx_i`. Otherwise `eng_rx_o` = `rx_pin_i`.
- R9: With autobaud set, `tx_pin_o` is 1 (recessive). Otherwise it follows `eng_tx_i`, with no register delay in the default build.
- R10: Read bit 4 is receive success. It is set by `frame_ok_i` when either `msg_store_i` or autobaud is high. It is cleared by a write with bit 7 set, or by reset execution; execution takes priority over setting.
- R11: After `rst_n` is released, all read bits are 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en_i | input | 1 | control register write strobe |
| wr_prot_i | input | 1 | protected-write qualifier |
| wr_data_i | input | DW | write data |
| rd_data_o | output | DW | control and status readback |
| rx_busy_i | input | 1 | engine receiving a frame |
| tx_busy_i | input | 1 | engine transmitting a frame |
| arb_lost_i | input | 1 | arbitration-loss handling in progress |
| err_act_i | input | 1 | error handling in progress |
| bus_off_i | input | 1 | engine in bus-off or recovering |
| frame_ok_i | input | 1 | frame received without error |
| msg_store_i | input | 1 | received frame stored to a buffer |
| rx_pin_i | input | 1 | raw bus receive pin |
| eng_tx_i | input | 1 | engine transmit bit |
| tx_pin_o | output | 1 | bus transmit pin |
| eng_rx_o | output | 1 | receive bit fed to the engine |
| reg_rst_o | output | 1 | engine register reset strobe |
| cnt_clr_o | output | 1 | error counter clear strobe |
| eng_hold_o | output | 1 | engine held in soft reset |
| run_o | output | 1 | release into normal operation |
| recover_o | output | 1 | release into bus-off recovery |

## Verification
Reset requests are made while each busy input is held on its own, with busy inputs overlapping, and with the engine idle. This shows whether each of the four conditions delays execution and whether an idle engine gives immediate execution. Release is tried with the flag set, with the flag cleared, and during bus-off, which separates the resume and recovery pulses. Autobaud is tried over all four RX and engine-TX combinations, in and out of the mode, which separates the ANDed loopback from plain pass-through. A long stretch of random writes, protection bits and busy traffic finds ordering conflicts between setting and clearing the flags.

// File: rtl/canfe_pkg.sv
package canfe_pkg;
   localparam int unsigned N_BUSY = 4;

   typedef struct packed {
      logic req;
      logic abaud;
      logic swint;
   } canfe_ctrl_t;

   function automatic logic any_busy(input logic [N_BUSY-1:0] b);
      return |b;
   endfunction
endpackage

// File: rtl/canfe_ctrl_reg.sv
module canfe_ctrl_reg
   import canfe_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned REQ_BIT = 0,
   parameter int unsigned AB_BIT  = 1,
   parameter int unsigned SW_BIT  = 2,
   parameter int unsigned CLR_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic          wr_prot_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          bus_off_i,
   input  logic          sw_set_i,
   input  logic          ok_set_i,
   input  logic          ok_kill_i,
   output canfe_ctrl_t   ctrl_o,
   output logic          rx_ok_o
);
   logic req_q, ab_q, sw_q, ok_q;
   logic prot_wr;

   assign prot_wr = wr_en_i & wr_prot_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         ab_q  <= 1'b0;
         sw_q  <= 1'b0;
         ok_q  <= 1'b0;
      end else begin
         if (prot_wr) req_q <= wr_data_i[REQ_BIT];
         if (wr_en_i) ab_q <= wr_data_i[AB_BIT];
         if (bus_off_i)      sw_q <= 1'b0;
         else if (sw_set_i)  sw_q <= 1'b1;
         else if (wr_en_i)   sw_q <= wr_data_i[SW_BIT];
         if (ok_kill_i)      ok_q <= 1'b0;
         else if (ok_set_i)  ok_q <= 1'b1;
         else if (wr_en_i && wr_data_i[CLR_BIT]) ok_q <= 1'b0;
      end
   end

   assign ctrl_o.req   = req_q;
   assign ctrl_o.abaud = ab_q;
   assign ctrl_o.swint = sw_q;
   assign rx_ok_o      = ok_q;

   // R1: an unprotected write never moves the request bit
   p_plain_wr_keeps_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_prot_i) |=> $stable(req_q));
endmodule

// File: rtl/canfe_rst_seq.sv
module canfe_rst_seq
   import canfe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [N_BUSY-1:0] busy_i,
   input  logic              bus_off_i,
   input  logic              swint_i,
   output logic              fire_o,
   output logic              done_o,
   output logic              run_o,
   output logic              recover_o,
   output logic              cnt_clr_o
);
   logic done_q, boff_q, busy, rel, bo_exit;

   assign busy    = any_busy(busy_i);
   assign fire_o  = req_i & ~done_q & ~busy;
   assign rel     = done_q & ~req_i;
   assign bo_exit = boff_q & ~bus_off_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         boff_q <= 1'b0;
      end else begin
         boff_q <= bus_off_i;
         if (fire_o)      done_q <= 1'b1;
         else if (!req_i) done_q <= 1'b0;
      end
   end

   assign done_o    = done_q;
   assign cnt_clr_o = fire_o | bo_exit;
   assign run_o     = rel & swint_i & ~bus_off_i;
   assign recover_o = rel & bus_off_i;

   // R2: pending request with bus activity stays unexecuted
   p_wait_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !done_q && busy) |=> !done_q);
   // R6: release outcomes are exclusive
   p_release_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_o && recover_o));
endmodule

// File: rtl/canfe_loop_path.sv
module canfe_loop_path #(
   parameter bit TX_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abaud_i,
   input  logic rx_pin_i,
   input  logic eng_tx_i,
   output logic tx_pin_o,
   output logic eng_rx_o
);
   localparam logic RECESSIVE = 1'b1;

   assign eng_rx_o = abaud_i ? (rx_pin_i & eng_tx_i) : rx_pin_i;

   generate
      if (TX_REG) begin : g_tx_flop
         logic tx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tx_q <= RECESSIVE;
            else        tx_q <= abaud_i ? RECESSIVE : eng_tx_i;
         end
         assign tx_pin_o = tx_q;
         // R9: one cycle after autobaud is seen, the pin is recessive
         p_tx_recessive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            abaud_i |=> tx_pin_o);
      end else begin : g_tx_comb
         assign tx_pin_o = abaud_i ? RECESSIVE : eng_tx_i;
         // R9: the pin never drives dominant in autobaud
         p_tx_recessive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            abaud_i |-> tx_pin_o);
      end
   endgenerate
endmodule

// File: rtl/canfe_rst_abaud.sv
module canfe_rst_abaud
   import canfe_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned REQ_BIT  = 0,
   parameter int unsigned AB_BIT   = 1,
   parameter int unsigned SW_BIT   = 2,
   parameter int unsigned DONE_BIT = 3,
   parameter int unsigned OK_BIT   = 4,
   parameter int unsigned CLR_BIT  = 7,
   parameter bit          TX_REG   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic          wr_prot_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          rx_busy_i,
   input  logic          tx_busy_i,
   input  logic          arb_lost_i,
   input  logic          err_act_i,
   input  logic          bus_off_i,
   input  logic          frame_ok_i,
   input  logic          msg_store_i,
   input  logic          rx_pin_i,
   input  logic          eng_tx_i,
   output logic          tx_pin_o,
   output logic          eng_rx_o,
   output logic          reg_rst_o,
   output logic          cnt_clr_o,
   output logic          eng_hold_o,
   output logic          run_o,
   output logic          recover_o
);
   localparam int unsigned MAX_BIT = DW - 1;

   generate
      if (REQ_BIT > MAX_BIT || AB_BIT > MAX_BIT || SW_BIT > MAX_BIT ||
          DONE_BIT > MAX_BIT || OK_BIT > MAX_BIT || CLR_BIT > MAX_BIT) begin : g_bad_pos
         $error("canfe_rst_abaud: field position beyond DW");
      end
      if (REQ_BIT == AB_BIT || REQ_BIT == SW_BIT || AB_BIT == SW_BIT) begin : g_bad_overlap
         $error("canfe_rst_abaud: writable fields overlap");
      end
   endgenerate

   canfe_ctrl_t       ctrl;
   logic              rx_ok, fire, done, ok_set;
   logic [N_BUSY-1:0] busy_vec;

   assign busy_vec = {err_act_i, arb_lost_i, tx_busy_i, rx_busy_i};
   assign ok_set   = frame_ok_i & (msg_store_i | ctrl.abaud);

   canfe_ctrl_reg #(
      .DW(DW), .REQ_BIT(REQ_BIT), .AB_BIT(AB_BIT), .SW_BIT(SW_BIT), .CLR_BIT(CLR_BIT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_prot_i(wr_prot_i), .wr_data_i(wr_data_i),
      .bus_off_i(bus_off_i), .sw_set_i(cnt_clr_o),
      .ok_set_i(ok_set), .ok_kill_i(fire),
      .ctrl_o(ctrl), .rx_ok_o(rx_ok)
   );

   canfe_rst_seq u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_i(ctrl.req), .busy_i(busy_vec),
      .bus_off_i(bus_off_i), .swint_i(ctrl.swint),
      .fire_o(fire), .done_o(done),
      .run_o(run_o), .recover_o(recover_o), .cnt_clr_o(cnt_clr_o)
   );

   canfe_loop_path #(.TX_REG(TX_REG)) u_loop (
      .clk(clk), .rst_n(rst_n), .abaud_i(ctrl.abaud),
      .rx_pin_i(rx_pin_i), .eng_tx_i(eng_tx_i),
      .tx_pin_o(tx_pin_o), .eng_rx_o(eng_rx_o)
   );

   always_comb begin
      rd_data_o           = '0;
      rd_data_o[REQ_BIT]  = ctrl.req;
      rd_data_o[AB_BIT]   = ctrl.abaud;
      rd_data_o[SW_BIT]   = ctrl.swint;
      rd_data_o[DONE_BIT] = done;
      rd_data_o[OK_BIT]   = rx_ok;
   end

   assign reg_rst_o  = fire;
   assign eng_hold_o = done;

   // R4: execution strobe is followed by the done status
   p_fire_sets_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rst_o |=> rd_data_o[DONE_BIT]);
   // R5: execution raises the software-interrupt flag
   p_fire_sets_swint_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rst_o && !bus_off_i) |=> rd_data_o[SW_BIT]);
   // R7: bus-off forces the flag low
   p_busoff_kills_swint_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off_i |=> !rd_data_o[SW_BIT]);
endmodule

// File: tb/canfe_rst_abaud_tb_top.sv
module canfe_rst_abaud_tb_top;
   localparam int CLK_P = 10;
   localparam int DW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, wr_prot = 0;
   logic [DW-1:0] wr_data = '0;
   logic rx_busy = 0, tx_busy = 0, arb_lost = 0, err_act = 0, bus_off = 0;
   logic frame_ok = 0, msg_store = 0, rx_pin = 1, eng_tx = 1;
   logic [DW-1:0] rd_data;
   logic tx_pin, eng_rx, reg_rst, cnt_clr, eng_hold, run, recover;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit running = 0;

   always #(CLK_P/2) clk = ~clk;

   canfe_rst_abaud dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_prot_i(wr_prot),
      .wr_data_i(wr_data), .rd_data_o(rd_data),
      .rx_busy_i(rx_busy), .tx_busy_i(tx_busy), .arb_lost_i(arb_lost),
      .err_act_i(err_act), .bus_off_i(bus_off), .frame_ok_i(frame_ok),
      .msg_store_i(msg_store), .rx_pin_i(rx_pin), .eng_tx_i(eng_tx),
      .tx_pin_o(tx_pin), .eng_rx_o(eng_rx), .reg_rst_o(reg_rst),
      .cnt_clr_o(cnt_clr), .eng_hold_o(eng_hold), .run_o(run), .recover_o(recover)
   );

   // behavioural reference state
   bit m_req, m_ab, m_sw, m_done, m_ok, m_boq;

   function automatic bit m_busy();
      return rx_busy | tx_busy | arb_lost | err_act;
   endfunction
   function automatic bit m_fire();
      return m_req && !m_done && !m_busy();
   endfunction
   function automatic bit m_rel();
      return m_done && !m_req;
   endfunction
   function automatic bit m_boexit();
      return m_boq && !bus_off;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_req <= 0; m_ab <= 0; m_sw <= 0; m_done <= 0; m_ok <= 0; m_boq <= 0;
      end else begin
         bit f, bx;
         f  = m_fire();
         bx = m_boexit();
         if (wr_en && wr_prot) m_req <= wr_data[0];
         if (wr_en) m_ab <= wr_data[1];
         if (bus_off) m_sw <= 0;
         else if (f || bx) m_sw <= 1;
         else if (wr_en) m_sw <= wr_data[2];
         if (f) m_done <= 1;
         else if (!m_req) m_done <= 0;
         if (f) m_ok <= 0;
         else if (frame_ok && (msg_store || m_ab)) m_ok <= 1;
         else if (wr_en && wr_data[7]) m_ok <= 0;
         m_boq <= bus_off;
      end
   end

   task automatic chk(input string tag, input logic act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   // per-cycle comparison, a quarter period after inputs change
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (running) begin
            chk("R1 req bit", rd_data[0], m_req);
            chk("R8 autobaud bit", rd_data[1], m_ab);
            chk("R5/R7 swint bit", rd_data[2], m_sw);
            chk("R4 done bit", rd_data[3], m_done);
            chk("R10 rx ok bit", rd_data[4], m_ok);
            chk("R11 unused read bits", |{rd_data[7:5]}, 1'b0);
            chk("R2/R3 reg_rst", reg_rst, m_fire());
            chk("R3/R7 cnt_clr", cnt_clr, m_fire() || m_boexit());
            chk("R6 hold", eng_hold, m_done);
            chk("R6 run", run, m_rel() && m_sw && !bus_off);
            chk("R6 recover", recover, m_rel() && bus_off);
            chk("R9 tx pin", tx_pin, m_ab ? 1'b1 : eng_tx);
            chk("R8 eng rx", eng_rx, m_ab ? (rx_pin & eng_tx) : rx_pin);
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [DW-1:0] d, input logic prot);
      @(negedge clk);
      wr_en = 1; wr_prot = prot; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_prot = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      tick(3);
      #1 rst_n = 1;
      @(negedge clk);
      #(CLK_P/4);
      // R11: reset state
      chk("R11 reset read", |rd_data, 1'b0);
      chk("R11 reset strobes", reg_rst | cnt_clr | eng_hold | run | recover, 1'b0);
      running = 1;

      // R1: ordinary write of the request is ignored
      wr(8'h01, 0);
      tick(2);
      chk("R1 plain write ignored", rd_data[0], 1'b0);

      // R2: each busy source delays execution
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         rx_busy = (k == 0); tx_busy = (k == 1); arb_lost = (k == 2); err_act = (k == 3);
         wr(8'h01, 1);
         tick(4);
         chk("R2 waits while busy", rd_data[3], 1'b0);
         rx_busy = 0; tx_busy = 0; arb_lost = 0; err_act = 0;
         tick(3);
         chk("R4 done after idle", rd_data[3], 1'b1);
         chk("R5 swint set", rd_data[2], 1'b1);
         wr(8'h00, 1);        // release with flag set: run pulse (R6)
         tick(2);
      end

      // overlapping busy, then immediate execution when idle
      rx_busy = 1; err_act = 1;
      wr(8'h01, 1);
      tick(2);
      rx_busy = 0; tick(2);
      err_act = 0; tick(2);
      wr(8'h00, 0);          // clear flag by ordinary write, request unchanged
      tick(1);
      wr(8'h00, 1);          // release with flag cleared: no pulse (R6)
      tick(2);

      // R7: bus-off blocks the flag, release goes to recovery
      wr(8'h01, 1);
      tick(2);
      bus_off = 1;
      wr(8'h05, 0);
      chk("R7 flag blocked in bus-off", rd_data[2], 1'b0);
      wr(8'h00, 1);
      tick(3);
      bus_off = 0;
      tick(2);
      chk("R7 flag set on bus-off exit", rd_data[2], 1'b1);

      // R8, R9: autobaud loopback across all pin combinations
      for (int m = 0; m < 2; m++) begin
         wr(m ? 8'h02 : 8'h00, 0);
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rx_pin = c[0]; eng_tx = c[1];
         end
      end

      // R10: success without store only in autobaud
      wr(8'h00, 0);
      @(negedge clk); frame_ok = 1; msg_store = 0;
      @(negedge clk); frame_ok = 0;
      tick(1);
      chk("R10 no store no autobaud", rd_data[4], 1'b0);
      wr(8'h02, 0);
      @(negedge clk); frame_ok = 1;
      @(negedge clk); frame_ok = 0;
      tick(1);
      chk("R10 autobaud success", rd_data[4], 1'b1);
      wr(8'h82, 0);
      tick(1);
      chk("R10 cleared by write", rd_data[4], 1'b0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         wr_en     = ($urandom_range(0, 5) == 0);
         wr_prot   = $urandom_range(0, 1);
         wr_data   = DW'($urandom);
         rx_busy   = ($urandom_range(0, 3) == 0);
         tx_busy   = ($urandom_range(0, 3) == 0);
         arb_lost  = ($urandom_range(0, 7) == 0);
         err_act   = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 40) == 0) bus_off = ~bus_off;
         frame_ok  = ($urandom_range(0, 5) == 0);
         msg_store = $urandom_range(0, 1);
         rx_pin    = $urandom_range(0, 1);
         eng_tx    = $urandom_range(0, 1);
      end
      @(negedge clk);
      wr_en = 0;
      tick(3);
      running = 0;
      summary();
   end
endmodule